// File: doc/BRIEF.md
# Bus Parity Generator with Phase-Gated Drive

This block computes the parity bit for a 32-bit multiplexed address/data bus and decides, clock by clock, whether that bit may be driven onto the shared parity line. It watches the bus control strobes and the arbitration grant. From them it tells an address phase from a completed data phase. It also records whether the transaction is a write and whether this agent was granted the bus.

Drive is gated separately for each phase. An address-phase parity bit goes out only when the grant was held during the address phase. A data-phase parity bit goes out for a write regardless of who mastered the transaction. The parity bit and its enable appear one clock after the phase they cover. A bypass input removes the block from the line so the parity line can be sourced elsewhere.

Top module: `pci_parity_gen`

## Requirements
- R1: Whenever `par_oe` is high, `par` makes the number of ones across `ad`, `cbe_n` (sampled on the previous clock) and `par` even.
- R2: An address phase in which `gnt_n` is low makes `par_oe` high on the following clock.
- R3: An address phase in which `gnt_n` is high leaves `par_oe` low on the following clock.
- R4: For a write transaction, every completed data phase makes `par_oe` high on the following clock, whatever `gnt_n` was. A transaction is a write when `cbe_n[0]` is 1 in its address phase; the memory write code is 0111.
- R5: For a read transaction (`cbe_n[0]` = 0 in the address phase, for example memory read 0110), completed data phases leave `par_oe` low.
- R6: A data phase completes only on a clock where `irdy_n` and `trdy_n` are both low; a wait-state clock leaves `par_oe` low on the following clock.
- R7: `par_oe` returns low two clocks after the final data phase, which is the completed data phase with `frame_n` high.
- R8: An address phase is recognised only on a clock with `frame_n` low that follows a clock with both `frame_n` and `irdy_n` high; `frame_n` falling straight after the final data phase is not one, and leaves `par_oe` low.
- R9: While `bypass` is high, `par_oe` is low.
- R10: During and just after reset, `par_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | High: never drive the parity line |
| ad | input | 32 | Multiplexed address/data lines |
| cbe_n | input | 4 | Command / byte-enable lines |
| frame_n | input | 1 | Transaction frame strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| gnt_n | input | 1 | Arbitration grant to this agent, active low |
| par | output | 1 | Even parity bit for the previous clock's lines |
| par_oe | output | 1 | Output enable for the parity line |

## Verification
The final completed data phase of one transaction and the start of another can meet. A final write data phase is followed at once by a falling `frame_n` with the grant held and a write code on `cbe_n`. The bench checks that the data-phase drive shows for one clock, and that the premature frame raises no address-phase drive. A proper address phase after an idle clock is then checked to be recognised normally. Wait-state clocks placed inside a write burst are judged the same way: each completed phase must produce its own one-clock drive, and each stalled phase must produce none.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  localparam int LANE_BITS = 8;
  localparam int CMD_WR_BIT = 0;

  typedef struct packed {
    logic addr_ph;
    logic owner;
    logic data_done;
    logic last_done;
    logic wr;
  } phase_ev_t;
endpackage

// File: rtl/pci_par_calc.sv
module pci_par_calc
  import pci_par_pkg::*;
#(
  parameter int LANES = 4,
  localparam int AD_W = LANE_BITS * LANES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad,
  input  logic [LANES-1:0] cbe_n,
  output logic            par_q
);
  function automatic logic lane_parity(input logic [LANE_BITS-1:0] b, input logic e);
    logic p;
    p = e;
    for (int i = 0; i < LANE_BITS; i++) p = p ^ b[i];
    return p;
  endfunction

  logic [LANES-1:0] lane_p;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_p[g] = lane_parity(ad[g*LANE_BITS +: LANE_BITS], cbe_n[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= 1'b0;
    else        par_q <= ^lane_p;
  end
endmodule

// File: rtl/pci_par_phase_trk.sv
module pci_par_phase_trk
  import pci_par_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_wr,
  input  logic      frame_n,
  input  logic      irdy_n,
  input  logic      trdy_n,
  input  logic      gnt_n,
  output phase_ev_t ev
);
  logic idle_q, busy_q, wr_q;
  logic bus_idle, addr_ph, data_done, last_done;

  assign bus_idle  = frame_n & irdy_n;
  assign addr_ph   = idle_q & ~frame_n;
  assign data_done = busy_q & ~irdy_n & ~trdy_n;
  assign last_done = data_done & frame_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      idle_q <= bus_idle;
      if (addr_ph) begin
        busy_q <= 1'b1;
        wr_q   <= cmd_wr;
      end else if (last_done || bus_idle) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign ev.addr_ph   = addr_ph;
  assign ev.owner     = ~gnt_n;
  assign ev.data_done = data_done;
  assign ev.last_done = last_done;
  assign ev.wr        = wr_q;

  // R8: an address phase needs an idle bus on the clock before
  a_r8_addr_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ph |-> ($past(frame_n) && $past(irdy_n)));

  // R6: a completed data phase needs both ready strobes low
  a_r6_done_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |-> (!irdy_n && !trdy_n && !addr_ph));
endmodule

// File: rtl/pci_par_drive.sv
module pci_par_drive
  import pci_par_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bypass,
  input  phase_ev_t ev,
  output logic      oe_q,
  output logic      par_oe
);
  logic addr_drv, data_drv;

  assign addr_drv = ev.addr_ph & ev.owner;
  assign data_drv = ev.data_done & ev.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= addr_drv | data_drv;
  end

  assign par_oe = oe_q & ~bypass;

  // R2: owned address phase enables drive on the next clock
  a_r2_addr_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.addr_ph && ev.owner) |=> oe_q);

  // R3: unowned address phase does not enable drive
  a_r3_addr_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.addr_ph && !ev.owner) |=> !oe_q);

  // R4: completed write data phase enables drive
  a_r4_write_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.data_done && ev.wr) |=> oe_q);

  // R5: completed read data phase does not enable drive
  a_r5_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.data_done && !ev.wr) |=> !oe_q);
endmodule

// File: rtl/pci_parity_gen.sv
module pci_parity_gen
  import pci_par_pkg::*;
#(
  parameter int LANES = 4,
  localparam int AD_W = LANE_BITS * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass,
  input  logic [AD_W-1:0]  ad,
  input  logic [LANES-1:0] cbe_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic             gnt_n,
  output logic             par,
  output logic             par_oe
);
  phase_ev_t ev;
  logic      oe_q;

  pci_par_calc #(.LANES(LANES)) calc_i (
    .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n), .par_q(par)
  );

  pci_par_phase_trk trk_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cbe_n[CMD_WR_BIT]),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .gnt_n(gnt_n),
    .ev(ev)
  );

  pci_par_drive drv_i (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .ev(ev),
    .oe_q(oe_q), .par_oe(par_oe)
  );

  // R1: driven parity makes the total count of ones even
  a_r1_even_total: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> ($countones({$past(ad), $past(cbe_n), par}) % 2 == 0));

  // R7: enable drops two clocks after the final data phase
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev.last_done |=> ##1 !oe_q);

  // R9: bypass keeps the line undriven
  a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !par_oe);
endmodule

// File: tb/pci_parity_gen_tb_top.sv
module pci_parity_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bypass = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, gnt_n = 1'b1;
  logic        par, par_oe;

  int checks = 0;
  int failures = 0;

  bit    exp_oe_q[$];
  bit    exp_par_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  pci_parity_gen dut_i (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .ad(ad), .cbe_n(cbe_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .gnt_n(gnt_n),
    .par(par), .par_oe(par_oe)
  );

  function automatic bit ref_par(input logic [31:0] a, input logic [3:0] c);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(a[i]);
    for (int i = 0; i < 4; i++) n += int'(c[i]);
    return bit'(n % 2);
  endfunction

  // driver: applies one clock of bus activity and queues the expected result
  task automatic cyc(input logic [31:0] a, input logic [3:0] c, input logic fr,
                     input logic ir, input logic tr, input logic gn, input logic byp,
                     input bit exp_oe, input string tag);
    @(negedge clk);
    ad = a; cbe_n = c; frame_n = fr; irdy_n = ir; trdy_n = tr; gnt_n = gn; bypass = byp;
    exp_oe_q.push_back(exp_oe);
    exp_par_q.push_back(ref_par(a, c));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    cyc(32'h0, 4'hF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, tag);
  endtask

  // monitor: compares outputs after each edge against the queue
  always @(posedge clk) begin
    #2;
    if (exp_oe_q.size() > 0) begin
      bit    eo, ep;
      string t;
      eo = exp_oe_q.pop_front();
      ep = exp_par_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if (par_oe !== eo) begin
        failures++;
        $display("FAIL %s par_oe actual=%b expected=%b", t, par_oe, eo);
      end
      if (eo) begin
        checks++;
        if (par !== ep) begin
          failures++;
          $display("FAIL R1 (%s) par actual=%b expected=%b", t, par, ep);
        end
      end
    end
  end

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (par_oe !== 1'b0) begin
      failures++;
      $display("FAIL R10 par_oe in reset actual=%b expected=0", par_oe);
    end
    rst_n = 1'b1;
    idle("R10 after reset");

    // master memory write (0111), single data phase
    cyc(32'h1234_5670, 4'b0111, 0, 1, 1, 0, 0, 1, "R2 owned addr");
    cyc(32'hFFFF_FFFF, 4'b0000, 1, 0, 0, 0, 0, 1, "R4 write data");
    idle("R7 release");
    idle("R7 stays low");

    // target write: grant not held
    cyc(32'h0000_0001, 4'b0111, 0, 1, 1, 1, 0, 0, "R3 foreign addr");
    cyc(32'h0000_0003, 4'b1010, 1, 0, 0, 1, 0, 1, "R4 write data not master");
    idle("R7 release");

    // master memory read (0110)
    cyc(32'h8000_0000, 4'b0110, 0, 1, 1, 0, 0, 1, "R2 owned read addr");
    cyc(32'hA5A5_5A5A, 4'b0000, 1, 0, 0, 0, 0, 0, "R5 read data");
    idle("R5 idle");

    // write burst with wait states
    cyc(32'h0F0F_0F0F, 4'b0111, 0, 1, 1, 0, 0, 1, "R2 burst addr");
    cyc(32'h1111_1111, 4'b0000, 0, 0, 1, 0, 0, 0, "R6 wait state");
    cyc(32'h1111_1111, 4'b0000, 0, 0, 0, 0, 0, 1, "R6 first done");
    cyc(32'h7777_0001, 4'b0011, 0, 1, 0, 0, 0, 0, "R6 initiator wait");
    cyc(32'h7777_0001, 4'b0011, 1, 0, 0, 0, 0, 1, "R6 final done");
    idle("R7 release after burst");

    // final data phase followed at once by a falling frame
    cyc(32'hDEAD_BEEF, 4'b0111, 0, 1, 1, 0, 0, 1, "R2 addr");
    cyc(32'h0000_00FF, 4'b1100, 1, 0, 0, 0, 0, 1, "R4 final write data");
    cyc(32'h2222_2222, 4'b0111, 0, 1, 1, 0, 0, 0, "R8 no idle before frame");
    cyc(32'h2222_2222, 4'b0111, 0, 1, 1, 0, 0, 0, "R8 frame held");
    idle("R8 idle");
    cyc(32'h3333_3333, 4'b0111, 0, 1, 1, 0, 0, 1, "R8 proper addr");
    cyc(32'h0000_0000, 4'b0000, 1, 0, 0, 0, 0, 1, "R4 write data");
    idle("R7 release");

    // bypass
    cyc(32'h4444_4444, 4'b0111, 0, 1, 1, 0, 1, 0, "R9 bypass addr");
    cyc(32'h0000_0001, 4'b0000, 1, 0, 0, 0, 1, 0, "R9 bypass data");
    idle("R9 idle");
    idle("R9 settle");

    while (exp_oe_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule